// File: doc/BRIEF.md
# HCI Link-Control Packet Responder

This block sits behind a serial deframer on the controller side of a host-controller link. It takes one complete packet at a time as a byte stream, the first byte being the packet type. It then decides what to do with it. Ordinary command, ACL and SCO packets go out unchanged on a host-side forward port. Link-control packets are answered locally on a transmit port: operational-setting negotiation, keep-alive probes, and the vendor firmware-download command.

The firmware-download command is always acknowledged with a fixed vendor event. When its data block carries the right record marker, a 48-bit device address is also taken from fixed, shuffled byte positions. Packets that fail their checks, and packet types the controller never receives, raise a one-cycle error pulse and produce no output. While a packet is being judged or answered, the block raises `busy` and drops any input bytes.

Top module: `hciResponder`

## Requirements
- R1: After reset `busy`, `txValid`, `fwdValid`, `errPulse` and `addrValid` are low and `devAddr` is zero.
- R2: A packet with type byte 0x02 (ACL), 0x03 (SCO), or 0x01 (command) whose byte 2 bits [7:2] are not 0x3F is sent out on the forward port byte for byte, with `fwdLast` on its final byte, and nothing is sent on the transmit port.
- R3: A packet of exactly 12 bytes equal to 06 0A 00 A0 01 00 00 4C 00 96 00 00 is answered on the transmit port with 12 bytes: 06, 0A, 20, then input bytes 2 to 8 in order, then FF, FF.
- R4: A type-0x06 packet whose length is not 12 or whose bytes differ from the pattern in R3 anywhere is bad.
- R5: A type-0x07 packet of length 4 with byte 2 = 0x55 and byte 3 = 0x00 is answered with 07 02 CC 00; any other type-0x07 packet is bad.
- R6: A command whose byte 1 is 0x00 and byte 2 is 0xFC (vendor group, sub-code 0) is not forwarded; it is answered with the 14-byte event 04 FF 0B followed by eleven 0x00 bytes.
- R7: For an R6 command of at least 30 bytes with byte 16 = 0x01 and byte 17 = 0x00, `devAddr` bytes 0 to 5 (bits [7:0] upward) take input bytes 29, 28, 26, 22, 25, 24, and `addrValid` pulses once; otherwise `devAddr` keeps its value.
- R8: A vendor-group command with a nonzero sub-code, any type-0x04 packet, and any type byte other than 01, 02, 03, 06, 07 is bad. A bad packet gives exactly one cycle of `errPulse` and no output on either port.
- R9: `busy` is high from the cycle after the last input byte until the reply is finished; bytes offered while `busy` is high are ignored.
- R10: A packet longer than MAX_LEN (default 64) bytes is bad; a packet of exactly MAX_LEN bytes is handled normally.
- R11: `txLast` and `fwdLast` mark only the final byte of each output stream, and the two ports are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inByte | input | 8 | Input packet byte |
| inLast | input | 1 | Marks the final byte of a packet |
| busy | output | 1 | Packet being judged or answered; input ignored |
| txValid | output | 1 | Transmit-queue byte valid |
| txByte | output | 8 | Response byte |
| txLast | output | 1 | Final response byte |
| fwdValid | output | 1 | Forward-port byte valid |
| fwdByte | output | 8 | Forwarded packet byte |
| fwdLast | output | 1 | Final forwarded byte |
| errPulse | output | 1 | One-cycle pulse per bad packet |
| devAddr | output | 48 | Captured device address |
| addrValid | output | 1 | Pulses when devAddr is loaded |

## Verification
The bench targets the shuffled address positions with a packet whose bytes are all distinct. A wrong offset or swapped byte therefore shows up as a wrong `devAddr`. The same packet with its record marker altered must leave the address alone. Negotiation packets that are one byte too long, or that differ in a single byte, must give an error and not an echo reply. A design that compared only the type byte would answer them. A vendor-group command with a nonzero sub-code and an inbound event packet must be rejected rather than forwarded. The buffer is pushed to exactly its depth and one packet past it, which catches an off-by-one overflow check. Bytes thrown at the block while it is replying must not start a phantom packet or add output.

// File: rtl/hciRspPkg.sv
`timescale 1ns/1ps
package hciRspPkg;

  typedef enum logic [2:0] {
    KIND_BAD,
    KIND_FWD,
    KIND_NEG,
    KIND_ALIVE,
    KIND_VEND
  } pktKind_e;

  typedef enum logic [1:0] {
    S_COLLECT,
    S_DECIDE,
    S_EMIT
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic clear;
    logic emitTx;
    logic emitFwd;
    logic emitLast;
    logic capAddr;
  } ctrlStrb_t;

  localparam logic [7:0] TYPE_CMD   = 8'h01;
  localparam logic [7:0] TYPE_ACL   = 8'h02;
  localparam logic [7:0] TYPE_SCO   = 8'h03;
  localparam logic [7:0] TYPE_EVT   = 8'h04;
  localparam logic [7:0] TYPE_NEG   = 8'h06;
  localparam logic [7:0] TYPE_ALIVE = 8'h07;

  localparam int NEG_LEN      = 12;
  localparam int ALIVE_LEN    = 4;
  localparam int VEND_RSP_LEN = 14;
  localparam int ADDR_MIN_LEN = 30;

  localparam logic [7:0] VEND_EVT_CODE = 8'hFF;
  localparam logic [7:0] VEND_EVT_PLEN = 8'h0B;
  localparam logic [7:0] NEG_OK_CODE   = 8'h20;
  localparam logic [7:0] ALIVE_ACK     = 8'hCC;

  function automatic logic [7:0] negPattern(input int unsigned pos);
    case (pos)
      0:       return 8'h06;
      1:       return 8'h0A;
      3:       return 8'hA0;
      4:       return 8'h01;
      7:       return 8'h4C;
      9:       return 8'h96;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hciRspData.sv
`timescale 1ns/1ps
module hciRspData
  import hciRspPkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LENW = $clog2(MAX_LEN + 1),
  localparam int IDXW = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  input  ctrlStrb_t        strb,
  input  logic [LENW-1:0]  idx,
  output pktKind_e         kind,
  output logic [LENW-1:0]  pktLen,
  output logic             addrHit,
  output logic             txValid,
  output logic [7:0]       txByte,
  output logic             txLast,
  output logic             fwdValid,
  output logic [7:0]       fwdByte,
  output logic             fwdLast,
  output logic [47:0]      devAddr,
  output logic             addrValid
);

  logic [7:0]      pktMem [MAX_LEN];
  logic [LENW-1:0] cnt;
  logic            ovf;

  // packet buffer fill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (strb.clear) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (strb.accept && inValid) begin
      if (cnt < LENW'(MAX_LEN)) begin
        pktMem[cnt[IDXW-1:0]] <= inByte;
        cnt <= cnt + 1'b1;
      end else begin
        ovf <= 1'b1;
      end
    end
  end

  assign pktLen = cnt;

  // negotiation pattern compare, one comparator per byte
  logic [NEG_LEN-1:0] negMatch;
  for (genvar g = 0; g < NEG_LEN; g++) begin : gNegCmp
    assign negMatch[g] = (pktMem[g] == negPattern(g));
  end

  logic negOk, aliveOk, vendGrp, ocfZero;
  assign negOk   = (cnt == LENW'(NEG_LEN)) && (&negMatch);
  assign aliveOk = (cnt == LENW'(ALIVE_LEN)) && (pktMem[2] == 8'h55) && (pktMem[3] == 8'h00);
  assign vendGrp = (cnt >= LENW'(3)) && (pktMem[2][7:2] == 6'h3F);
  assign ocfZero = (pktMem[2][1:0] == 2'b00) && (pktMem[1] == 8'h00);
  assign addrHit = (cnt >= LENW'(ADDR_MIN_LEN)) && (pktMem[16] == 8'h01) && (pktMem[17] == 8'h00);

  always_comb begin
    kind = KIND_BAD;
    if (!ovf && cnt != '0) begin
      unique case (pktMem[0])
        TYPE_CMD:   kind = vendGrp ? (ocfZero ? KIND_VEND : KIND_BAD) : KIND_FWD;
        TYPE_ACL,
        TYPE_SCO:   kind = KIND_FWD;
        TYPE_NEG:   kind = negOk ? KIND_NEG : KIND_BAD;
        TYPE_ALIVE: kind = aliveOk ? KIND_ALIVE : KIND_BAD;
        default:    kind = KIND_BAD;
      endcase
    end
  end

  // response byte for the current emit index
  logic [LENW-1:0] prevIdx;
  logic [7:0]      rspByte;
  assign prevIdx = idx - 1'b1;

  always_comb begin
    rspByte = 8'h00;
    unique case (kind)
      KIND_NEG: begin
        if (idx == LENW'(0))       rspByte = TYPE_NEG;
        else if (idx == LENW'(1))  rspByte = 8'(NEG_LEN - 2);
        else if (idx == LENW'(2))  rspByte = NEG_OK_CODE;
        else if (idx < LENW'(10))  rspByte = pktMem[prevIdx[IDXW-1:0]];
        else                       rspByte = 8'hFF;
      end
      KIND_ALIVE: begin
        if (idx == LENW'(0))       rspByte = TYPE_ALIVE;
        else if (idx == LENW'(1))  rspByte = 8'h02;
        else if (idx == LENW'(2))  rspByte = ALIVE_ACK;
        else                       rspByte = 8'h00;
      end
      KIND_VEND: begin
        if (idx == LENW'(0))       rspByte = TYPE_EVT;
        else if (idx == LENW'(1))  rspByte = VEND_EVT_CODE;
        else if (idx == LENW'(2))  rspByte = VEND_EVT_PLEN;
        else                       rspByte = 8'h00;
      end
      default: rspByte = 8'h00;
    endcase
  end

  // registered output ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid   <= 1'b0;
      txByte    <= '0;
      txLast    <= 1'b0;
      fwdValid  <= 1'b0;
      fwdByte   <= '0;
      fwdLast   <= 1'b0;
      devAddr   <= '0;
      addrValid <= 1'b0;
    end else begin
      txValid   <= strb.emitTx;
      txByte    <= strb.emitTx ? rspByte : 8'h00;
      txLast    <= strb.emitTx && strb.emitLast;
      fwdValid  <= strb.emitFwd;
      fwdByte   <= strb.emitFwd ? pktMem[idx[IDXW-1:0]] : 8'h00;
      fwdLast   <= strb.emitFwd && strb.emitLast;
      addrValid <= strb.capAddr;
      if (strb.capAddr) begin
        devAddr <= {pktMem[24], pktMem[25], pktMem[22], pktMem[26], pktMem[28], pktMem[29]};
      end
    end
  end

endmodule

// File: rtl/hciRspCtrl.sv
`timescale 1ns/1ps
module hciRspCtrl
  import hciRspPkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LENW = $clog2(MAX_LEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inLast,
  input  pktKind_e        kind,
  input  logic [LENW-1:0] pktLen,
  input  logic            addrHit,
  output ctrlStrb_t       strb,
  output logic [LENW-1:0] idx,
  output logic            busy,
  output logic            errPulse
);

  ctrlState_e      state;
  logic [LENW-1:0] emitLen;
  logic            toFwd;
  logic            lastStep;
  logic [LENW-1:0] rspLen;

  assign lastStep = (idx == emitLen - 1'b1);
  assign busy     = (state != S_COLLECT);

  always_comb begin
    unique case (kind)
      KIND_NEG:   rspLen = LENW'(NEG_LEN);
      KIND_ALIVE: rspLen = LENW'(ALIVE_LEN);
      KIND_VEND:  rspLen = LENW'(VEND_RSP_LEN);
      default:    rspLen = pktLen;
    endcase
  end

  always_comb begin
    strb.accept   = (state == S_COLLECT);
    strb.clear    = ((state == S_DECIDE) && (kind == KIND_BAD)) ||
                    ((state == S_EMIT) && lastStep);
    strb.emitTx   = (state == S_EMIT) && !toFwd;
    strb.emitFwd  = (state == S_EMIT) && toFwd;
    strb.emitLast = (state == S_EMIT) && lastStep;
    strb.capAddr  = (state == S_DECIDE) && (kind == KIND_VEND) && addrHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_COLLECT;
      idx      <= '0;
      emitLen  <= '0;
      toFwd    <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= 1'b0;
      unique case (state)
        S_COLLECT: begin
          if (inValid && inLast) state <= S_DECIDE;
        end
        S_DECIDE: begin
          idx     <= '0;
          emitLen <= rspLen;
          toFwd   <= (kind == KIND_FWD);
          if (kind == KIND_BAD) begin
            errPulse <= 1'b1;
            state    <= S_COLLECT;
          end else begin
            state <= S_EMIT;
          end
        end
        S_EMIT: begin
          idx <= idx + 1'b1;
          if (lastStep) state <= S_COLLECT;
        end
        default: state <= S_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/hciResponder.sv
`timescale 1ns/1ps
module hciResponder
  import hciRspPkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inLast,
  output logic        busy,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic        txLast,
  output logic        fwdValid,
  output logic [7:0]  fwdByte,
  output logic        fwdLast,
  output logic        errPulse,
  output logic [47:0] devAddr,
  output logic        addrValid
);

  localparam int LENW = $clog2(MAX_LEN + 1);

  ctrlStrb_t       strb;
  logic [LENW-1:0] idx;
  logic [LENW-1:0] pktLen;
  pktKind_e        kind;
  logic            addrHit;

  hciRspCtrl #(.MAX_LEN(MAX_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .kind(kind), .pktLen(pktLen), .addrHit(addrHit),
    .strb(strb), .idx(idx), .busy(busy), .errPulse(errPulse)
  );

  hciRspData #(.MAX_LEN(MAX_LEN)) uData (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .strb(strb), .idx(idx), .kind(kind), .pktLen(pktLen), .addrHit(addrHit),
    .txValid(txValid), .txByte(txByte), .txLast(txLast),
    .fwdValid(fwdValid), .fwdByte(fwdByte), .fwdLast(fwdLast),
    .devAddr(devAddr), .addrValid(addrValid)
  );

endmodule

// File: rtl/hciRspChecker.sv
`timescale 1ns/1ps
module hciRspChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        txValid,
  input logic        txLast,
  input logic        fwdValid,
  input logic        fwdLast,
  input logic        errPulse,
  input logic        addrValid,
  input logic [47:0] devAddr
);

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && fwdValid)); // R11

  AST_TX_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R11

  AST_FWD_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    fwdLast |-> fwdValid); // R11

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse); // R8

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!txValid && !fwdValid)); // R8

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !busy); // R9

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (addrValid || $stable(devAddr))); // R7

endmodule

bind hciResponder hciRspChecker uChk (
  .clk(clk), .rstN(rstN), .busy(busy),
  .txValid(txValid), .txLast(txLast),
  .fwdValid(fwdValid), .fwdLast(fwdLast),
  .errPulse(errPulse), .addrValid(addrValid), .devAddr(devAddr)
);

// File: tb/sim_hciResponder.sv
`timescale 1ns/1ps
module sim_hciResponder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inLast = 1'b0;
  logic        busy, txValid, txLast, fwdValid, fwdLast, errPulse, addrValid;
  logic [7:0]  txByte, fwdByte;
  logic [47:0] devAddr;

  always #2 clk = ~clk;

  hciResponder u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .inLast(inLast),
    .busy(busy), .txValid(txValid), .txByte(txByte), .txLast(txLast),
    .fwdValid(fwdValid), .fwdByte(fwdByte), .fwdLast(fwdLast),
    .errPulse(errPulse), .devAddr(devAddr), .addrValid(addrValid)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int errSeen = 0;
  int errExp = 0;
  int addrSeen = 0;
  int addrExp = 0;
  bit done = 1'b0;
  string curReq = "R1";

  logic [8:0] txQ[$];
  logic [8:0] fwdQ[$];
  logic [7:0] pkt[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (txValid) begin
        if (txQ.size() == 0) chk(1'b0, curReq, "unexpected tx byte", {55'd0, txLast, txByte}, 64'h0);
        else begin
          logic [8:0] e;
          e = txQ.pop_front();
          chk({txLast, txByte} == e, curReq, "tx byte/last", {55'd0, txLast, txByte}, {55'd0, e});
        end
      end
      if (fwdValid) begin
        if (fwdQ.size() == 0) chk(1'b0, curReq, "unexpected fwd byte", {55'd0, fwdLast, fwdByte}, 64'h0);
        else begin
          logic [8:0] e;
          e = fwdQ.pop_front();
          chk({fwdLast, fwdByte} == e, curReq, "fwd byte/last", {55'd0, fwdLast, fwdByte}, {55'd0, e});
        end
      end
      if (txValid && fwdValid) chk(1'b0, "R11", "both ports valid", 64'h1, 64'h0);
      if (errPulse) errSeen++;
      if (addrValid) addrSeen++;
    end
  end

  task automatic sendPkt();
    for (int i = 0; i < pkt.size(); i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inByte  = pkt[i];
      inLast  = (i == pkt.size() - 1);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic expFwdAll();
    for (int i = 0; i < pkt.size(); i++) fwdQ.push_back({i == pkt.size() - 1, pkt[i]});
  endtask

  task automatic expTx(input logic [7:0] b[$]);
    for (int i = 0; i < b.size(); i++) txQ.push_back({i == b.size() - 1, b[i]});
  endtask

  task automatic settle(input string req);
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(txQ.size() == 0, req, "tx bytes missing", txQ.size(), 0);
    chk(fwdQ.size() == 0, req, "fwd bytes missing", fwdQ.size(), 0);
    chk(errSeen == errExp, req, "error pulse count", errSeen, errExp);
    chk(addrSeen == addrExp, req, "addr pulse count", addrSeen, addrExp);
    txQ.delete();
    fwdQ.delete();
    errSeen = errExp;
    addrSeen = addrExp;
  endtask

  task automatic fillSeq(input int n, input logic [7:0] t);
    pkt.delete();
    for (int i = 0; i < n; i++) pkt.push_back(i == 0 ? t : 8'(8'h30 + i));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, curReq, "watchdog expired", 0, 1);
    finishRun();
  end

  logic [47:0] addrKeep;

  initial begin
    logic [7:0] r[$];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, txValid, fwdValid, errPulse, addrValid} == 5'b0, "R1", "outputs at reset",
        {busy, txValid, fwdValid, errPulse, addrValid}, 0);
    chk(devAddr == 48'd0, "R1", "devAddr at reset", devAddr, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 forwarding
    curReq = "R2";
    fillSeq(8, 8'h02); expFwdAll(); sendPkt(); settle("R2");
    fillSeq(5, 8'h03); expFwdAll(); sendPkt(); settle("R2");
    pkt = '{8'h01, 8'h03, 8'h0C, 8'h00}; expFwdAll(); sendPkt(); settle("R2");

    // R3 negotiation reply
    curReq = "R3";
    pkt = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00, 8'h00};
    r = '{8'h06, 8'h0A, 8'h20};
    for (int i = 2; i <= 8; i++) r.push_back(pkt[i]);
    r.push_back(8'hFF); r.push_back(8'hFF);
    expTx(r); sendPkt(); settle("R3");

    // R4 bad negotiation: one byte off, one byte too long
    curReq = "R4";
    pkt = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4D, 8'h00, 8'h96, 8'h00, 8'h00};
    errExp++; sendPkt(); settle("R4");
    pkt = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00, 8'h00, 8'h00};
    errExp++; sendPkt(); settle("R4");

    // R5 keep-alive
    curReq = "R5";
    pkt = '{8'h07, 8'h02, 8'h55, 8'h00};
    r = '{8'h07, 8'h02, 8'hCC, 8'h00}; expTx(r); sendPkt(); settle("R5");
    pkt = '{8'h07, 8'h02, 8'h55, 8'h01}; errExp++; sendPkt(); settle("R5");

    // R6 short vendor command: event, address untouched
    curReq = "R6";
    r = '{8'h04, 8'hFF, 8'h0B};
    for (int i = 0; i < 11; i++) r.push_back(8'h00);
    pkt = '{8'h01, 8'h00, 8'hFC, 8'h02, 8'hAA, 8'hBB};
    expTx(r); sendPkt(); settle("R6");
    chk(devAddr == 48'd0, "R7", "short vendor cmd leaves address", devAddr, 0);

    // R7 address capture from shuffled offsets
    curReq = "R7";
    fillSeq(30, 8'h01);
    pkt[1] = 8'h00; pkt[2] = 8'hFC; pkt[3] = 8'h1A; pkt[16] = 8'h01; pkt[17] = 8'h00;
    addrKeep = {pkt[24], pkt[25], pkt[22], pkt[26], pkt[28], pkt[29]};
    addrExp++; expTx(r); sendPkt(); settle("R7");
    chk(devAddr == addrKeep, "R7", "captured address", devAddr, addrKeep);
    pkt[16] = 8'h02; pkt[29] = 8'hEE;
    expTx(r); sendPkt(); settle("R7");
    chk(devAddr == addrKeep, "R7", "marker mismatch keeps address", devAddr, addrKeep);

    // R8 rejected packets
    curReq = "R8";
    pkt = '{8'h01, 8'h01, 8'hFC, 8'h00}; errExp++; sendPkt(); settle("R8");
    pkt = '{8'h04, 8'h0E, 8'h00};        errExp++; sendPkt(); settle("R8");
    pkt = '{8'h09, 8'h00};               errExp++; sendPkt(); settle("R8");

    // R9 input ignored while busy
    curReq = "R9";
    fillSeq(20, 8'h02); expFwdAll(); sendPkt();
    chk(busy == 1'b1, "R9", "busy after last byte", busy, 1);
    for (int i = 0; i < 4; i++) begin
      inValid = 1'b1; inByte = 8'h09; inLast = 1'b1;
      @(negedge clk);
    end
    inValid = 1'b0; inLast = 1'b0;
    settle("R9");
    pkt = '{8'h07, 8'h02, 8'h55, 8'h00};
    r = '{8'h07, 8'h02, 8'hCC, 8'h00}; expTx(r); sendPkt(); settle("R9");

    // R10 buffer depth
    curReq = "R10";
    fillSeq(64, 8'h02); expFwdAll(); sendPkt(); settle("R10");
    fillSeq(65, 8'h02); errExp++; sendPkt(); settle("R10");

    finishRun();
  end

endmodule